// File: doc/BRIEF.md
# Decode-Stage Branch Resolver

This block settles control-flow decisions while the instruction is still in the decode stage of a five-stage pipeline. A taken branch therefore costs one lost fetch slot, not three. It has its own zero detector on the compared register, its own target adder, and a jump-target former. From these it chooses the resolved successor address and tells the fetch unit when to abandon its sequential address.

A one-bit policy input chooses how the slot after a control instruction is treated. With the predict-not-taken policy, fetch runs ahead sequentially. When a redirect happens, the instruction already fetched is discarded by clearing the fetch/decode valid bit, which the block owns. With the delay-slot policy, that instruction always proceeds and nothing is discarded. While the hazard unit reports that decode operands are not yet available, the block makes no decision and holds the valid bit.

Top module: `branch_resolver_top`

## Requirements
- R1: While `rst_n` is low, `dec_valid` is 0 and `redirect` and `squash` are 0.
- R2: A conditional branch (`is_branch`=1) is taken when `cond_ne`=0 and `rs_val` equals zero, or when `cond_ne`=1 and `rs_val` is non-zero.
- R3: For a taken branch, `next_pc` = `pc_plus4` + (sign-extended `imm` shifted left by 2), modulo 2^32, and `redirect` is 1.
- R4: For a branch that is not taken, `next_pc` = `pc_plus4` and `redirect` is 0.
- R5: A jump (`is_jump`=1, which overrides `is_branch`) always redirects, with `next_pc` = {`pc_plus4`[31:28], `jfield`, 2'b00}.
- R6: When `mode_sel`=0 (predict-not-taken), `squash` is 1 exactly when `redirect` is 1.
- R7: When `mode_sel`=1 (delay slot), `squash` is always 0.
- R8: On each clock edge where decode is not held, `dec_valid` loads 0 if `squash` is 1, and loads `fetch_valid` otherwise.
- R9: When `ops_ready`=0, `redirect` and `squash` are 0 and `dec_valid` keeps its value across the edge.
- R10: When `dec_valid`=0, `redirect` and `squash` are 0 even for a control instruction.
- R11: For an instruction that is neither branch nor jump, `redirect` is 0 and `next_pc` = `pc_plus4`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | Slot policy: 0 predict-not-taken, 1 delay slot |
| fetch_valid | input | 1 | The instruction fetched this cycle is valid |
| ops_ready | input | 1 | Decode operands are available (0 = hazard hold) |
| is_branch | input | 1 | Decode instruction is a conditional branch |
| cond_ne | input | 1 | Branch condition: 0 equal-zero, 1 not-equal-zero |
| is_jump | input | 1 | Decode instruction is an unconditional jump |
| rs_val | input | 32 | Compared register operand |
| pc_plus4 | input | 32 | Address of the decode instruction plus 4 |
| imm | input | 16 | Branch word offset |
| jfield | input | 26 | Jump target field |
| next_pc | output | 32 | Resolved successor address |
| redirect | output | 1 | Fetch must take `next_pc` at the next edge |
| squash | output | 1 | The fetched successor is being discarded |
| dec_valid | output | 1 | Fetch/decode entry valid bit |

## Verification
The bench drives negative, most-negative and most-positive offsets, and an addition that wraps past the top of the address space. A design that zero-extends the offset or forgets the word scaling would land on the wrong target. It checks that a jump keeps only the upper address nibble and ignores the register, so a jump routed through the branch adder would show. Both policies are run on the same taken and untaken cases, so a squash that leaks into delay-slot mode or is missing in predict-not-taken mode shows at the port, and the valid bit is checked after the edge. Hazard holds and invalid decode entries are exercised with a taken condition present, which catches a design that redirects on stale operands or bubbles.

// File: rtl/br_pkg.sv
package br_pkg;
  typedef enum logic {
    POL_PREDICT_NT = 1'b0,
    POL_DELAY_SLOT = 1'b1
  } br_policy_e;

  typedef enum logic {
    COND_EQZ = 1'b0,
    COND_NEZ = 1'b1
  } br_cond_e;
endpackage

// File: rtl/br_zero_test.sv
module br_zero_test #(
  parameter int DW   = 32,
  parameter int LANE = 8
) (
  input  logic [DW-1:0]  opnd,
  input  br_pkg::br_cond_e cond,
  output logic           cond_true
);
  localparam int NLANE = (DW + LANE - 1) / LANE;
  localparam int PW    = NLANE * LANE;

  logic [PW-1:0]    padded;
  logic [NLANE-1:0] lane_any;
  logic             is_zero;

  always_comb begin
    padded          = '0;
    padded[DW-1:0]  = opnd;
  end

  // two-level reduction keeps the zero test shallow in decode
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    assign lane_any[g] = |padded[g*LANE +: LANE];
  end

  always_comb begin
    is_zero   = ~|lane_any;
    cond_true = (cond == br_pkg::COND_NEZ) ? ~is_zero : is_zero;
  end
endmodule

// File: rtl/br_target_gen.sv
module br_target_gen #(
  parameter int AW = 32,
  parameter int IW = 16,
  parameter int JW = 26
) (
  input  logic [AW-1:0] pc_plus4,
  input  logic [IW-1:0] imm,
  input  logic [JW-1:0] jfield,
  output logic [AW-1:0] br_target,
  output logic [AW-1:0] jmp_target
);
  localparam int EXT = AW - IW - 2;

  logic [AW-1:0] offset;

  always_comb begin
    offset    = {{EXT{imm[IW-1]}}, imm, 2'b00};
    br_target = pc_plus4 + offset;
  end

  if (JW + 2 < AW) begin : g_region
    assign jmp_target = {pc_plus4[AW-1:JW+2], jfield, 2'b00};
  end else begin : g_full
    logic [JW+1:0] wide;
    assign wide       = {jfield, 2'b00};
    assign jmp_target = wide[AW-1:0];
  end
endmodule

// File: rtl/br_policy.sv
module br_policy #(
  parameter int AW = 32
) (
  input  logic               dec_valid,
  input  logic               ops_ready,
  input  logic               is_branch,
  input  logic               is_jump,
  input  logic               cond_true,
  input  br_pkg::br_policy_e policy,
  input  logic [AW-1:0]      pc_plus4,
  input  logic [AW-1:0]      br_target,
  input  logic [AW-1:0]      jmp_target,
  output logic [AW-1:0]      next_pc,
  output logic               redirect,
  output logic               squash
);
  logic decide;
  logic taken;

  always_comb begin
    decide = dec_valid & ops_ready;
    taken  = is_jump | (is_branch & cond_true);
    if (is_jump)
      next_pc = jmp_target;
    else if (is_branch && cond_true)
      next_pc = br_target;
    else
      next_pc = pc_plus4;
    redirect = decide & taken;
    squash   = redirect & (policy == br_pkg::POL_PREDICT_NT);
  end
endmodule

// File: rtl/branch_resolver_top.sv
module branch_resolver_top #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int IW = 16,
  parameter int JW = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_sel,
  input  logic          fetch_valid,
  input  logic          ops_ready,
  input  logic          is_branch,
  input  logic          cond_ne,
  input  logic          is_jump,
  input  logic [DW-1:0] rs_val,
  input  logic [AW-1:0] pc_plus4,
  input  logic [IW-1:0] imm,
  input  logic [JW-1:0] jfield,
  output logic [AW-1:0] next_pc,
  output logic          redirect,
  output logic          squash,
  output logic          dec_valid
);
  br_pkg::br_policy_e policy;
  br_pkg::br_cond_e   cond;
  logic               cond_true;
  logic [AW-1:0]      br_target;
  logic [AW-1:0]      jmp_target;
  logic               valid_q;
  logic               valid_d;
  logic               valid_en;

  assign policy    = br_pkg::br_policy_e'(mode_sel);
  assign cond      = br_pkg::br_cond_e'(cond_ne);
  assign dec_valid = valid_q;

  br_zero_test #(.DW(DW)) zero_i (
    .opnd      (rs_val),
    .cond      (cond),
    .cond_true (cond_true)
  );

  br_target_gen #(.AW(AW), .IW(IW), .JW(JW)) tgt_i (
    .pc_plus4   (pc_plus4),
    .imm        (imm),
    .jfield     (jfield),
    .br_target  (br_target),
    .jmp_target (jmp_target)
  );

  br_policy #(.AW(AW)) pol_i (
    .dec_valid  (valid_q),
    .ops_ready  (ops_ready),
    .is_branch  (is_branch),
    .is_jump    (is_jump),
    .cond_true  (cond_true),
    .policy     (policy),
    .pc_plus4   (pc_plus4),
    .br_target  (br_target),
    .jmp_target (jmp_target),
    .next_pc    (next_pc),
    .redirect   (redirect),
    .squash     (squash)
  );

  // fetch/decode valid bit: held on a hazard, cleared by a squash
  always_comb begin
    valid_en = ops_ready;
    valid_d  = squash ? 1'b0 : fetch_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      valid_q <= 1'b0;
    else if (valid_en)
      valid_q <= valid_d;
  end
endmodule

// File: rtl/branch_resolver_chk.sv
module branch_resolver_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mode_sel,
  input logic          ops_ready,
  input logic          is_branch,
  input logic          is_jump,
  input logic [AW-1:0] pc_plus4,
  input logic [AW-1:0] next_pc,
  input logic          redirect,
  input logic          squash,
  input logic          dec_valid
);
  // R6
  pnt_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_sel && redirect) |-> squash);

  // R7
  delay_no_squash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_sel |-> !squash);

  // R8
  squash_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> !dec_valid);

  // R9
  hold_no_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ops_ready |-> (!redirect && !squash));

  // R9
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ops_ready |=> $stable(dec_valid));

  // R10
  bubble_no_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !redirect);

  // R4
  untaken_fallthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && ops_ready && is_branch && !is_jump && !redirect) |-> (next_pc == pc_plus4));
endmodule

bind branch_resolver_top branch_resolver_chk #(.AW(AW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_sel  (mode_sel),
  .ops_ready (ops_ready),
  .is_branch (is_branch),
  .is_jump   (is_jump),
  .pc_plus4  (pc_plus4),
  .next_pc   (next_pc),
  .redirect  (redirect),
  .squash    (squash),
  .dec_valid (dec_valid)
);

// File: tb/branch_resolver_top_tb_top.sv
`timescale 1ns/1ps
module branch_resolver_top_tb_top;
  logic        clk;
  logic        rst_n;
  logic        mode_sel;
  logic        fetch_valid;
  logic        ops_ready;
  logic        is_branch;
  logic        cond_ne;
  logic        is_jump;
  logic [31:0] rs_val;
  logic [31:0] pc_plus4;
  logic [15:0] imm;
  logic [25:0] jfield;
  logic [31:0] next_pc;
  logic        redirect;
  logic        squash;
  logic        dec_valid;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  branch_resolver_top dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .fetch_valid(fetch_valid),
    .ops_ready(ops_ready), .is_branch(is_branch), .cond_ne(cond_ne),
    .is_jump(is_jump), .rs_val(rs_val), .pc_plus4(pc_plus4), .imm(imm),
    .jfield(jfield), .next_pc(next_pc), .redirect(redirect),
    .squash(squash), .dec_valid(dec_valid)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic        mode;
    logic        br;
    logic        ne;
    logic        jmp;
    logic [31:0] rs;
    logic [31:0] pc4;
    logic [15:0] im;
    logic [25:0] jf;
    logic        e_red;
    logic        e_sq;
    logic [31:0] e_npc;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,1'b0,1'b0,32'h0,32'h00001000,16'h0010,26'h0,1'b1,1'b1,32'h00001040},
    '{1'b0,1'b1,1'b0,1'b0,32'h5,32'h00001000,16'h0010,26'h0,1'b0,1'b0,32'h00001000},
    '{1'b0,1'b1,1'b1,1'b0,32'h5,32'h00002000,16'hFFFF,26'h0,1'b1,1'b1,32'h00001FFC},
    '{1'b0,1'b1,1'b1,1'b0,32'h0,32'h00002000,16'hFFFF,26'h0,1'b0,1'b0,32'h00002000},
    '{1'b1,1'b1,1'b0,1'b0,32'h0,32'h00400008,16'h8000,26'h0,1'b1,1'b0,32'h003E0008},
    '{1'b1,1'b1,1'b1,1'b0,32'h80000000,32'h00000010,16'h7FFF,26'h0,1'b1,1'b0,32'h0002000C},
    '{1'b0,1'b0,1'b0,1'b1,32'h0,32'hA0000004,16'h0,26'h0123456,1'b1,1'b1,32'hA048D158},
    '{1'b1,1'b1,1'b0,1'b1,32'h7,32'h70000000,16'h0040,26'h0000001,1'b1,1'b0,32'h70000004},
    '{1'b0,1'b0,1'b0,1'b0,32'h0,32'h00000044,16'h0010,26'h0,1'b0,1'b0,32'h00000044},
    '{1'b1,1'b1,1'b0,1'b0,32'h1,32'h00000080,16'h0005,26'h0,1'b0,1'b0,32'h00000080},
    '{1'b0,1'b1,1'b1,1'b0,32'h1,32'hFFFFFFF0,16'h0008,26'h0,1'b1,1'b1,32'h00000010}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic set_idle();
    is_branch = 1'b0; is_jump = 1'b0; cond_ne = 1'b0;
    rs_val = '0; pc_plus4 = '0; imm = '0; jfield = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; mode_sel = 1'b0; fetch_valid = 1'b1; ops_ready = 1'b1;
    set_idle();
    is_branch = 1'b1; rs_val = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state with a taken branch presented
    check("R1", "dec_valid", {31'b0, dec_valid}, 32'h0);
    check("R1", "redirect", {31'b0, redirect}, 32'h0);
    check("R1", "squash", {31'b0, squash}, 32'h0);
    set_idle();
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R8", "dec_valid loads fetch_valid", {31'b0, dec_valid}, 32'h1);

    // table walk: R2 R3 R4 R5 R6 R7 R11, then R8 after the edge
    for (int i = 0; i < NV; i++) begin
      mode_sel = VECS[i].mode; is_branch = VECS[i].br; cond_ne = VECS[i].ne;
      is_jump = VECS[i].jmp; rs_val = VECS[i].rs; pc_plus4 = VECS[i].pc4;
      imm = VECS[i].im; jfield = VECS[i].jf;
      #1;
      check("R2/R3/R4/R5/R11", $sformatf("vec%0d next_pc", i), next_pc, VECS[i].e_npc);
      check("R2/R5", $sformatf("vec%0d redirect", i), {31'b0, redirect}, {31'b0, VECS[i].e_red});
      check(VECS[i].mode ? "R7" : "R6", $sformatf("vec%0d squash", i),
            {31'b0, squash}, {31'b0, VECS[i].e_sq});
      @(posedge clk); @(negedge clk);
      check("R8", $sformatf("vec%0d dec_valid after edge", i),
            {31'b0, dec_valid}, {31'b0, !VECS[i].e_sq});
      set_idle();
      @(posedge clk); @(negedge clk);
    end

    // R9: hazard hold with a taken branch in decode
    mode_sel = 1'b0; ops_ready = 1'b0; is_branch = 1'b1; rs_val = '0;
    pc_plus4 = 32'h100; imm = 16'h4; fetch_valid = 1'b0;
    #1;
    check("R9", "redirect on hold", {31'b0, redirect}, 32'h0);
    check("R9", "squash on hold", {31'b0, squash}, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R9", "dec_valid held", {31'b0, dec_valid}, 32'h1);
    ops_ready = 1'b1;
    #1;
    check("R9", "redirect once ready", {31'b0, redirect}, 32'h1);
    check("R3", "target once ready", next_pc, 32'h00000110);
    @(posedge clk); @(negedge clk);
    check("R8", "squash cleared valid", {31'b0, dec_valid}, 32'h0);

    // R10: bubble in decode with a taken jump and branch presented
    is_jump = 1'b1; jfield = 26'h10;
    #1;
    check("R10", "redirect on bubble", {31'b0, redirect}, 32'h0);
    check("R10", "squash on bubble", {31'b0, squash}, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R8", "fetch_valid=0 loaded", {31'b0, dec_valid}, 32'h0);

    // R7: delay-slot policy jump keeps the successor
    set_idle(); fetch_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    mode_sel = 1'b1; is_jump = 1'b1; jfield = 26'h3; pc_plus4 = 32'h50000000;
    #1;
    check("R5", "delay jump target", next_pc, 32'h5000000C);
    check("R7", "delay jump squash", {31'b0, squash}, 32'h0);
    @(posedge clk); @(negedge clk);
    check("R7", "delay slot kept valid", {31'b0, dec_valid}, 32'h1);

    finish_run();
  end
endmodule